// File: doc/BRIEF.md
# Processor IO Window Bridge

This block sits between a big-endian processor memory bus and a little-endian, byte-addressed IO port bus. A 64 KB aperture at a fixed base address is turned into IO port cycles: the port number is the bus address minus the base, and the data lanes are reordered according to the access size so that multi-byte values keep their numeric meaning across the endian boundary.

A second, four-byte aperture serves interrupt acknowledge. A read of its first byte runs one acknowledge cycle to an external interrupt controller and returns the vector it supplies. Writes there are swallowed. Any access that falls in neither aperture is flagged as a decode miss.

The processor side is single-issue. A read or write strobe is accepted only while the bridge is idle. The bridge then reports busy until it pulses `cpu_done`, and read data and the miss flag are valid in that cycle. Strobes presented while busy are dropped.

Top module: `pio_window_bridge`

## Requirements
- R1: An access in 0x8000_0000..0x8000_FFFF with a valid size drives `io_addr` equal to the bus address minus 0x8000_0000. `io_rd` (for a read) or `io_wr` (for a write) is asserted, together with `io_size` equal to the request size.
- R2: Size code 0 (byte) passes the low 8 bits through unchanged in both directions. Bits above them are zero on `io_wdata` and on `cpu_rdata`.
- R3: Size code 1 (halfword) swaps the two low bytes on write data and on returned read data. The upper 16 bits are zero.
- R4: Size code 2 (word) reverses all four bytes on write data and on returned read data.
- R5: A read of exactly 0xBFFF_FFF0 raises `iack_req` for exactly one cycle. `cpu_rdata` returns `iack_vec`, sampled in that cycle, zero-extended.
- R6: A write of any valid size to 0xBFFF_FFF0..0xBFFF_FFF3 completes with `cpu_miss` low, with no `iack_req` and no IO strobe.
- R7: A read of 0xBFFF_FFF1..0xBFFF_FFF3 completes with `cpu_rdata` zero, `cpu_miss` low and no `iack_req`.
- R8: An access outside both apertures completes with `cpu_miss` high, `cpu_rdata` zero and no IO strobe.
- R9: `cpu_busy` is high from the cycle after a strobe is accepted until the cycle after `cpu_done`. `io_rd`/`io_wr` and `io_addr` stay steady until `io_ready` is seen. `cpu_done` is a one-cycle pulse. Strobes arriving while busy are ignored.
- R10: Size code 3 is reserved. Such an access is treated as a decode miss in either aperture.
- R11: After reset, `cpu_busy`, `cpu_done`, `io_rd`, `io_wr` and `iack_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| cpu_rd | input | 1 | Read strobe (wins over write) |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| cpu_busy | output | 1 | Transaction in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_miss | output | 1 | Decode miss, valid with cpu_done |
| io_addr | output | 16 | IO port number |
| io_wdata | output | 32 | Lane-ordered write data |
| io_size | output | 2 | IO access size |
| io_rd | output | 1 | IO read strobe, held until ready |
| io_wr | output | 1 | IO write strobe, held until ready |
| io_ready | input | 1 | IO cycle completion |
| io_rdata | input | 32 | IO read data |
| iack_req | output | 1 | Interrupt acknowledge pulse |
| iack_vec | input | 8 | Vector from the interrupt controller |

## Verification
The bench covers every size in both directions and checks the exact byte order. A bridge that swapped byte accesses, or left halfwords unswapped, would return a mirrored value. The window edges (offset 0x0000, offset 0xFFFC, the first address above the window and the last address below it) would show a base compare of the wrong width as a miss or a stray IO cycle. The acknowledge aperture is tested at its live offset, at a dead offset and with a write: a decoder that ignores the low address bits or the direction would pulse `iack_req` where it must not. A strobe sent during a slow IO cycle would start a second transaction in a bridge that fails to block new requests while busy.

// File: rtl/pio_bridge_pkg.sv
package pio_bridge_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IO   = 2'd1,
    ST_IACK = 2'd2,
    ST_RESP = 2'd3
  } xact_state_e;

  // Endian lane reorder for one access size; unused upper lanes are zero.
  function automatic logic [DATA_W-1:0] lane_order(input logic [DATA_W-1:0] d,
                                                   input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    r = '0;
    case (sz)
      SZ_BYTE: r[7:0]  = d[7:0];
      SZ_HALF: r[15:0] = {d[7:0], d[15:8]};
      SZ_WORD: r       = {d[7:0], d[15:8], d[23:16], d[31:24]};
      default: r       = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode #(
  parameter logic [31:0] IO_BASE   = 32'h8000_0000,
  parameter int          IO_AW     = 16,
  parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0
) (
  input  logic [31:0]      addr,
  input  logic [1:0]       size,
  output logic             hit_io,
  output logic             hit_iack,
  output logic             iack_live,
  output logic             size_bad,
  output logic [IO_AW-1:0] port_addr
);
  import pio_bridge_pkg::*;
  localparam int IACK_AW = 2;

  logic [31:0] offs;
  assign offs      = addr - IO_BASE;
  assign hit_io    = (addr[31:IO_AW] == IO_BASE[31:IO_AW]);
  assign hit_iack  = (addr[31:IACK_AW] == IACK_ADDR[31:IACK_AW]);
  assign iack_live = hit_iack && (addr[IACK_AW-1:0] == IACK_ADDR[IACK_AW-1:0]);
  assign size_bad  = (size == SZ_RSVD);
  assign port_addr = offs[IO_AW-1:0];
endmodule

// File: rtl/pio_lane_swap.sv
module pio_lane_swap (
  input  logic [31:0] din,
  input  logic [1:0]  size,
  output logic [31:0] dout
);
  import pio_bridge_pkg::*;
  assign dout = lane_order(din, size);
endmodule

// File: rtl/pio_xact_ctrl.sv
module pio_xact_ctrl #(
  parameter int IO_AW = 16,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [1:0]       cpu_size,
  input  logic             hit_io,
  input  logic             hit_iack,
  input  logic             iack_live,
  input  logic             size_bad,
  input  logic [IO_AW-1:0] port_addr,
  input  logic [31:0]      wdata_sw,
  input  logic [31:0]      rdata_sw,
  input  logic             io_ready,
  input  logic [VEC_W-1:0] iack_vec,
  output logic [IO_AW-1:0] io_addr,
  output logic [31:0]      io_wdata,
  output logic [1:0]       io_size,
  output logic             io_rd,
  output logic             io_wr,
  output logic             iack_req,
  output logic [31:0]      cpu_rdata,
  output logic             cpu_busy,
  output logic             cpu_done,
  output logic             cpu_miss,
  output logic             evt_accept,
  output logic             evt_io_end
);
  import pio_bridge_pkg::*;

  xact_state_e state;
  logic        dir_rd;
  logic        miss_d;

  assign evt_accept = (state == ST_IDLE) && (cpu_rd || cpu_wr);
  assign evt_io_end = (state == ST_IO) && io_ready;
  assign miss_d     = size_bad || (!hit_io && !hit_iack);
  assign io_rd      = (state == ST_IO) && dir_rd;
  assign io_wr      = (state == ST_IO) && !dir_rd;
  assign iack_req   = (state == ST_IACK);
  assign cpu_busy   = (state != ST_IDLE);
  assign cpu_done   = (state == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dir_rd    <= 1'b0;
      io_addr   <= '0;
      io_wdata  <= '0;
      io_size   <= '0;
      cpu_rdata <= '0;
      cpu_miss  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (evt_accept) begin
          cpu_rdata <= '0;
          cpu_miss  <= miss_d;
          dir_rd    <= cpu_rd;
          if (miss_d) begin
            state <= ST_RESP;
          end else if (hit_io) begin
            io_addr  <= port_addr;
            io_wdata <= wdata_sw;
            io_size  <= cpu_size;
            state    <= ST_IO;
          end else if (cpu_rd && iack_live) begin
            state <= ST_IACK;
          end else begin
            state <= ST_RESP;
          end
        end
        ST_IO: if (io_ready) begin
          if (dir_rd) cpu_rdata <= rdata_sw;
          state <= ST_RESP;
        end
        ST_IACK: begin
          cpu_rdata <= {{(32-VEC_W){1'b0}}, iack_vec};
          state     <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_window_bridge.sv
module pio_window_bridge #(
  parameter logic [31:0] IO_BASE   = 32'h8000_0000,
  parameter int          IO_AW     = 16,
  parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0,
  parameter int          VEC_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cpu_addr,
  input  logic [31:0]      cpu_wdata,
  input  logic [1:0]       cpu_size,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  output logic [31:0]      cpu_rdata,
  output logic             cpu_busy,
  output logic             cpu_done,
  output logic             cpu_miss,
  output logic [IO_AW-1:0] io_addr,
  output logic [31:0]      io_wdata,
  output logic [1:0]       io_size,
  output logic             io_rd,
  output logic             io_wr,
  input  logic             io_ready,
  input  logic [31:0]      io_rdata,
  output logic             iack_req,
  input  logic [VEC_W-1:0] iack_vec
);
  logic             hit_io, hit_iack, iack_live, size_bad;
  logic [IO_AW-1:0] port_addr;
  logic [31:0]      wdata_sw, rdata_sw;
  logic             evt_accept, evt_io_end;

  pio_addr_decode #(.IO_BASE(IO_BASE), .IO_AW(IO_AW), .IACK_ADDR(IACK_ADDR)) u_dec (
    .addr(cpu_addr), .size(cpu_size), .hit_io(hit_io), .hit_iack(hit_iack),
    .iack_live(iack_live), .size_bad(size_bad), .port_addr(port_addr)
  );

  pio_lane_swap u_wswap (.din(cpu_wdata), .size(cpu_size), .dout(wdata_sw));
  pio_lane_swap u_rswap (.din(io_rdata),  .size(io_size),  .dout(rdata_sw));

  pio_xact_ctrl #(.IO_AW(IO_AW), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_size(cpu_size),
    .hit_io(hit_io), .hit_iack(hit_iack), .iack_live(iack_live), .size_bad(size_bad),
    .port_addr(port_addr), .wdata_sw(wdata_sw), .rdata_sw(rdata_sw),
    .io_ready(io_ready), .iack_vec(iack_vec), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_size(io_size), .io_rd(io_rd), .io_wr(io_wr), .iack_req(iack_req),
    .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
    .cpu_miss(cpu_miss), .evt_accept(evt_accept), .evt_io_end(evt_io_end)
  );
endmodule

// File: rtl/pio_window_bridge_chk.sv
module pio_window_bridge_chk #(
  parameter logic [31:0] IO_BASE = 32'h8000_0000,
  parameter int          IO_AW   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      cpu_addr,
  input logic [1:0]       cpu_size,
  input logic             cpu_busy,
  input logic             cpu_done,
  input logic             cpu_miss,
  input logic [31:0]      cpu_rdata,
  input logic [IO_AW-1:0] io_addr,
  input logic             io_rd,
  input logic             io_wr,
  input logic             io_ready,
  input logic             iack_req,
  input logic             evt_accept,
  input logic             hit_io
);
  AST_PORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && hit_io && (cpu_size != 2'd3) |=>
      (io_addr == IO_AW'($past(cpu_addr) - IO_BASE)) && (io_rd || io_wr)); // R1
  AST_IACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req |=> !iack_req && cpu_done); // R5
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && cpu_miss |-> (cpu_rdata == 32'd0) && !io_rd && !io_wr); // R8
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) && !io_ready |=> $stable(io_addr) && $stable(io_rd) && $stable(io_wr)); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_rd, io_wr, iack_req, cpu_done})); // R9
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_busy && !cpu_done); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> cpu_busy); // R9
endmodule

bind pio_window_bridge pio_window_bridge_chk #(.IO_BASE(IO_BASE), .IO_AW(IO_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
  .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_miss(cpu_miss), .cpu_rdata(cpu_rdata),
  .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_ready(io_ready),
  .iack_req(iack_req), .evt_accept(evt_accept), .hit_io(hit_io)
);

// File: tb/pio_window_bridge_tb.sv
`timescale 1ns/1ps
module pio_window_bridge_tb;
  localparam real CLK_P = 4.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [1:0]  cpu_size = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_rdata;
  logic        cpu_busy, cpu_done, cpu_miss;
  logic [15:0] io_addr;
  logic [31:0] io_wdata;
  logic [1:0]  io_size;
  logic        io_rd, io_wr, iack_req;
  logic        io_ready = 1'b0;
  logic [31:0] io_rdata = '0;
  logic [7:0]  iack_vec = '0;

  always #(CLK_P/2) clk = ~clk;

  pio_window_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_size(cpu_size), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_miss(cpu_miss), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_size(io_size), .io_rd(io_rd), .io_wr(io_wr),
    .io_ready(io_ready), .io_rdata(io_rdata), .iack_req(iack_req), .iack_vec(iack_vec)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // IO device responder: raises ready after lat wait cycles, records the cycle.
  int          lat = 0, wcnt = 0, io_cnt = 0, iack_cnt = 0;
  logic [31:0] dev_data = '0;
  logic [15:0] seen_addr = '0;
  logic [31:0] seen_wdata = '0;
  logic [1:0]  seen_size = '0;
  logic        seen_rd = 1'b0;
  always @(posedge clk) begin
    if (iack_req) iack_cnt <= iack_cnt + 1;
    if (io_ready) begin
      io_ready <= 1'b0;
      wcnt     <= 0;
    end else if (io_rd || io_wr) begin
      if (wcnt == lat) begin
        io_ready   <= 1'b1;
        io_rdata   <= dev_data;
        seen_addr  <= io_addr;
        seen_wdata <= io_wdata;
        seen_size  <= io_size;
        seen_rd    <= io_rd;
        io_cnt     <= io_cnt + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  // Bench's own lane model: move byte k of the value to the mirrored lane.
  function automatic logic [31:0] mirror(input logic [31:0] v, input int nbytes);
    logic [31:0] r = '0;
    for (int k = 0; k < nbytes; k++) r[8*(nbytes-1-k) +: 8] = v[8*k +: 8];
    return r;
  endfunction

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  size;
    logic        rd;
    logic [31:0] dev;
    logic [7:0]  vec;
    logic        exp_io;
    logic [15:0] exp_port;
    logic [31:0] exp_data;
    logic        exp_miss;
    logic        exp_iack;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{32'h8000_0060, 32'h0000_00A5, 2'd0, 1'b0, 32'h0,         8'h00, 1'b1, 16'h0060, 32'h0000_00A5, 1'b0, 1'b0}, // R2 R1
    '{32'h8000_0061, 32'h0,         2'd0, 1'b1, 32'h1234_5677, 8'h00, 1'b1, 16'h0061, 32'h0000_0077, 1'b0, 1'b0}, // R2
    '{32'h8000_01F0, 32'h0000_BEEF, 2'd1, 1'b0, 32'h0,         8'h00, 1'b1, 16'h01F0, 32'h0000_EFBE, 1'b0, 1'b0}, // R3
    '{32'h8000_01F2, 32'h0,         2'd1, 1'b1, 32'h5555_CAFE, 8'h00, 1'b1, 16'h01F2, 32'h0000_FECA, 1'b0, 1'b0}, // R3
    '{32'h8000_0CF8, 32'h1122_3344, 2'd2, 1'b0, 32'h0,         8'h00, 1'b1, 16'h0CF8, 32'h4433_2211, 1'b0, 1'b0}, // R4
    '{32'h8000_FFFC, 32'h0,         2'd2, 1'b1, 32'hA1B2_C3D4, 8'h00, 1'b1, 16'hFFFC, 32'hD4C3_B2A1, 1'b0, 1'b0}, // R4 R1
    '{32'h8000_0000, 32'h0,         2'd2, 1'b1, 32'h89AB_CDEF, 8'h00, 1'b1, 16'h0000, 32'hEFCD_AB89, 1'b0, 1'b0}, // R4 R1
    '{32'hBFFF_FFF0, 32'h0,         2'd0, 1'b1, 32'h0,         8'h2B, 1'b0, 16'h0000, 32'h0000_002B, 1'b0, 1'b1}, // R5
    '{32'hBFFF_FFF2, 32'h0,         2'd0, 1'b1, 32'h0,         8'h3C, 1'b0, 16'h0000, 32'h0000_0000, 1'b0, 1'b0}, // R7
    '{32'hBFFF_FFF0, 32'hDEAD_BEEF, 2'd2, 1'b0, 32'h0,         8'h4D, 1'b0, 16'h0000, 32'h0000_0000, 1'b0, 1'b0}, // R6
    '{32'h7FFF_FFFC, 32'h0,         2'd2, 1'b1, 32'hFFFF_FFFF, 8'h00, 1'b0, 16'h0000, 32'h0000_0000, 1'b1, 1'b0}, // R8
    '{32'h8001_0000, 32'h0000_0011, 2'd0, 1'b0, 32'h0,         8'h00, 1'b0, 16'h0000, 32'h0000_0000, 1'b1, 1'b0}, // R8
    '{32'h8000_0010, 32'h0,         2'd3, 1'b1, 32'hFFFF_FFFF, 8'h00, 1'b0, 16'h0000, 32'h0000_0000, 1'b1, 1'b0}  // R10
  };

  function automatic string tag_of(input vec_t v);
    if (v.size == 2'd3) return "R10";
    if (v.exp_miss)     return "R8";
    if (v.exp_iack)     return "R5";
    if (v.addr[31:28] == 4'hB) return v.rd ? "R7" : "R6";
    case (v.size)
      2'd0:    return "R2";
      2'd1:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] wd, input logic [1:0] sz, input bit rd);
    cpu_addr = a; cpu_wdata = wd; cpu_size = sz; cpu_rd = rd; cpu_wr = !rd;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int t = 0; t < 60; t++) begin
      if (cpu_done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    int io0, ia0;
    repeat (3) @(negedge clk);
    // R11: outputs quiet under reset
    chk({cpu_busy, cpu_done, io_rd, io_wr, iack_req} == 5'b0, "R11 reset",
        {27'b0, cpu_busy, cpu_done, io_rd, io_wr, iack_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_busy && !cpu_done, "R11 idle after reset", {31'b0, cpu_busy}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = TBL[i];
      string rq = tag_of(v);
      lat = i % 3; dev_data = v.dev; iack_vec = v.vec;
      io0 = io_cnt; ia0 = iack_cnt;
      issue(v.addr, v.wdata, v.size, v.rd);
      wait_done(ok);
      chk(ok, {rq, " done"}, {31'b0, ok}, 32'd1);
      if (v.rd) chk(cpu_rdata == v.exp_data, {rq, " rdata"}, cpu_rdata, v.exp_data);
      chk(cpu_miss == v.exp_miss, {rq, " miss"}, {31'b0, cpu_miss}, {31'b0, v.exp_miss});
      chk((iack_cnt - ia0) == int'(v.exp_iack), {rq, " iack count"},
          iack_cnt - ia0, {31'b0, v.exp_iack});
      chk((io_cnt - io0) == int'(v.exp_io), {rq, " io cycles"}, io_cnt - io0, {31'b0, v.exp_io});
      if (v.exp_io) begin
        chk(seen_addr == v.exp_port, "R1 port", {16'b0, seen_addr}, {16'b0, v.exp_port});
        chk(seen_size == v.size && seen_rd == v.rd, "R1 size/dir",
            {29'b0, seen_rd, seen_size}, {29'b0, v.rd, v.size});
        if (!v.rd) begin
          chk(seen_wdata == v.exp_data, {rq, " wdata"}, seen_wdata, v.exp_data);
          chk(seen_wdata == mirror(v.wdata, 1 << v.size), {rq, " wdata model"},
              seen_wdata, mirror(v.wdata, 1 << v.size));
        end
      end
      @(negedge clk);
      chk(!cpu_busy, "R9 release", {31'b0, cpu_busy}, 32'd0);
    end

    // R9: slow IO read, strobe held, second strobe during busy dropped
    lat = 3; dev_data = 32'h0102_0304;
    io0 = io_cnt;
    issue(32'h8000_0100, 32'h0, 2'd2, 1'b1);
    chk(cpu_busy && io_rd, "R9 busy+strobe", {30'b0, cpu_busy, io_rd}, 32'd3);
    cpu_addr = 32'h7000_0000; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    chk(io_rd && io_addr == 16'h0100, "R9 strobe held", {15'b0, io_rd, io_addr}, 32'h0001_0100);
    wait_done(ok);
    chk(ok && !cpu_miss && cpu_rdata == 32'h0403_0201, "R9 slow read",
        cpu_rdata, 32'h0403_0201);
    repeat (3) @(negedge clk);
    chk(!cpu_busy && !cpu_done && (io_cnt - io0) == 1, "R9 ignored strobe",
        {30'b0, cpu_busy, cpu_done}, 32'd0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule